// File: doc/BRIEF.md
# Reset Sequencer with Short/Long Classification

This block is a clocked reset controller for a microcontroller-class system. It watches an active-low reset input that has already passed through an analog filter. A low level must persist long enough to count as a real reset request; shorter pulses are ignored. A qualified request starts a fixed-length internal reset sequence, and the system reset output is held asserted for the whole of it.

In bidirectional mode the block pulls the reset pin low itself for the length of the internal sequence. A few cycles after the sequence ends, the block takes one sample of the filtered input. A high sample means the event was a short reset. A low sample means the input is still held low, so the event is a long reset. Only a long reset opens a 3-bit group of clock-configuration pins so that clock options can be latched again. The pins close a short, fixed time after the input returns high.

The timing parameters are the qualification time (16 cycles, the first 4 of which are detection), the sequence length (1024 cycles), the settle delay before the sample (8 cycles) and the close delay (4 cycles).

Top module: `rstseq_top`

## Requirements
- R1: A reset request qualifies only when `rst_in_n` is sampled low on 4 consecutive rising edges. A low run of 3 or fewer samples is rejected and changes no output, and the flags keep their values.
- R2: `sys_rst` rises in the cycle after the 4th low sample. For a short event it stays high for exactly 1044 cycles: the rest of qualification (12), the sequence (1024) and the settle delay (8).
- R3: With `bidir_en` = 1, `pin_drive` is high for exactly 1024 consecutive cycles, starting 12 cycles after `sys_rst` rises. With `bidir_en` = 0 it is never high.
- R4: On the 8th cycle after the sequence ends, `rst_in_n` is sampled once. A high sample sets `short_flag` = 1 and `long_flag` = 0. A low sample sets `long_flag` = 1 and `short_flag` = 0.
- R5: On a long event, `sys_rst` stays high until `rst_in_n` is sampled high. It falls in the cycle after that sample.
- R6: `cfg_open` is high only after a long classification. It runs from the cycle after the sample until 4 cycles after `sys_rst` falls, and it is never high on a short event.
- R7: `long_flag` and `short_flag` are never both high. They hold their values until the next qualified request, which clears both when `sys_rst` rises.
- R8: Changes on `rst_in_n` from qualification up to the sample point do not alter the event's timing or start a second event.
- R9: While `por_n` is low, and directly after it is released, every output is low.
- R10: Once the sequencer is idle again, a fresh qualifying low run starts a complete new sequence from qualification.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_in_n | input | 1 | Filtered reset request, active low |
| bidir_en | input | 1 | 1: drive the reset pin low during the sequence |
| sys_rst | output | 1 | System reset, active high |
| pin_drive | output | 1 | Enable for the open-drain pull-down of the reset pin |
| long_flag | output | 1 | Last event was a long reset |
| short_flag | output | 1 | Last event was a short reset |
| cfg_open | output | 1 | Clock-configuration pin group transparent |

## Verification
The hardest case to reach is a long reset caused by the block's own pin drive. In bidirectional mode a short external pulse can still be classified as long when the analog filter is slower than the settle delay. To create this, the bench models the pin as a wired-AND of the external source and `pin_drive`, and passes the result through a filter delay of a chosen number of cycles. A delay of 3 cycles must give a short reset, and a delay of 10 cycles must give a long one. The bench also places the sample point exactly on a boundary. Unidirectional low runs of 1047 and 1048 cycles fall just either side of it.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DETECT,
        ST_QUAL,
        ST_SEQ,
        ST_SETTLE,
        ST_HOLD,
        ST_CLOSE
    } seq_state_e;

    typedef struct packed {
        logic lng;
        logic sht;
    } flags_t;

endpackage

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl
    import rstseq_pkg::*;
#(
    parameter int DETECT_CYC = 4,
    parameter int QUAL_CYC   = 16,
    parameter int SEQ_CYC    = 1024,
    parameter int SETTLE_CYC = 8,
    parameter int CLOSE_CYC  = 4
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       rst_in_n,
    output seq_state_e state_o,
    output logic       clr_o,
    output logic       cls_o,
    output logic       cls_long_o
);

    localparam int CW = $clog2(SEQ_CYC + 1);
    localparam logic [CW-1:0] DET_LAST   = CW'(DETECT_CYC - 2);
    localparam logic [CW-1:0] QUAL_LAST  = CW'(QUAL_CYC - DETECT_CYC - 1);
    localparam logic [CW-1:0] SEQ_LAST   = CW'(SEQ_CYC - 1);
    localparam logic [CW-1:0] SET_LAST   = CW'(SETTLE_CYC - 1);
    localparam logic [CW-1:0] CLOSE_LAST = CW'(CLOSE_CYC - 1);

    typedef struct packed {
        seq_state_e     st;
        logic [CW-1:0]  cnt;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d     = ctrl_q;
        clr_o      = 1'b0;
        cls_o      = 1'b0;
        cls_long_o = 1'b0;
        case (ctrl_q.st)
            ST_IDLE: begin
                if (!rst_in_n) begin
                    ctrl_d.st  = ST_DETECT;
                    ctrl_d.cnt = '0;
                end
            end
            ST_DETECT: begin
                if (rst_in_n) begin
                    ctrl_d.st = ST_IDLE;
                end else if (ctrl_q.cnt == DET_LAST) begin
                    ctrl_d.st  = ST_QUAL;
                    ctrl_d.cnt = '0;
                    clr_o      = 1'b1;
                end else begin
                    ctrl_d.cnt = ctrl_q.cnt + CW'(1);
                end
            end
            ST_QUAL: begin
                if (ctrl_q.cnt == QUAL_LAST) begin
                    ctrl_d.st  = ST_SEQ;
                    ctrl_d.cnt = '0;
                end else begin
                    ctrl_d.cnt = ctrl_q.cnt + CW'(1);
                end
            end
            ST_SEQ: begin
                if (ctrl_q.cnt == SEQ_LAST) begin
                    ctrl_d.st  = ST_SETTLE;
                    ctrl_d.cnt = '0;
                end else begin
                    ctrl_d.cnt = ctrl_q.cnt + CW'(1);
                end
            end
            ST_SETTLE: begin
                if (ctrl_q.cnt == SET_LAST) begin
                    cls_o      = 1'b1;
                    cls_long_o = !rst_in_n;
                    ctrl_d.st  = rst_in_n ? ST_IDLE : ST_HOLD;
                    ctrl_d.cnt = '0;
                end else begin
                    ctrl_d.cnt = ctrl_q.cnt + CW'(1);
                end
            end
            ST_HOLD: begin
                if (rst_in_n) begin
                    ctrl_d.st  = ST_CLOSE;
                    ctrl_d.cnt = '0;
                end
            end
            ST_CLOSE: begin
                if (ctrl_q.cnt == CLOSE_LAST) begin
                    ctrl_d.st  = ST_IDLE;
                    ctrl_d.cnt = '0;
                end else begin
                    ctrl_d.cnt = ctrl_q.cnt + CW'(1);
                end
            end
            default: begin
                ctrl_d.st  = ST_IDLE;
                ctrl_d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            ctrl_q <= '{st: ST_IDLE, cnt: '0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign state_o = ctrl_q.st;

endmodule

// File: rtl/rstseq_classify.sv
module rstseq_classify
    import rstseq_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic clr_i,
    input  logic cls_i,
    input  logic cls_long_i,
    output logic long_o,
    output logic short_o
);

    flags_t flags_d, flags_q;

    always_comb begin
        flags_d = flags_q;
        if (clr_i) begin
            flags_d = '{lng: 1'b0, sht: 1'b0};
        end else if (cls_i) begin
            flags_d = '{lng: cls_long_i, sht: !cls_long_i};
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            flags_q <= '{lng: 1'b0, sht: 1'b0};
        end else begin
            flags_q <= flags_d;
        end
    end

    assign long_o  = flags_q.lng;
    assign short_o = flags_q.sht;

endmodule

// File: rtl/rstseq_outdec.sv
module rstseq_outdec
    import rstseq_pkg::*;
(
    input  seq_state_e state_i,
    input  logic       bidir_en,
    output logic       sys_rst_o,
    output logic       drive_o,
    output logic       cfg_o
);

    always_comb begin
        sys_rst_o = 1'b0;
        drive_o   = 1'b0;
        cfg_o     = 1'b0;
        case (state_i)
            ST_QUAL, ST_SETTLE: sys_rst_o = 1'b1;
            ST_SEQ: begin
                sys_rst_o = 1'b1;
                drive_o   = bidir_en;
            end
            ST_HOLD: begin
                sys_rst_o = 1'b1;
                cfg_o     = 1'b1;
            end
            ST_CLOSE: cfg_o = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
    import rstseq_pkg::*;
#(
    parameter int DETECT_CYC = 4,
    parameter int QUAL_CYC   = 16,
    parameter int SEQ_CYC    = 1024,
    parameter int SETTLE_CYC = 8,
    parameter int CLOSE_CYC  = 4
) (
    input  logic clk,
    input  logic por_n,
    input  logic rst_in_n,
    input  logic bidir_en,
    output logic sys_rst,
    output logic pin_drive,
    output logic long_flag,
    output logic short_flag,
    output logic cfg_open
);

    seq_state_e state;
    logic       clr;
    logic       cls;
    logic       cls_long;

    rstseq_ctrl #(
        .DETECT_CYC (DETECT_CYC),
        .QUAL_CYC   (QUAL_CYC),
        .SEQ_CYC    (SEQ_CYC),
        .SETTLE_CYC (SETTLE_CYC),
        .CLOSE_CYC  (CLOSE_CYC)
    ) u_ctrl (
        .clk        (clk),
        .por_n      (por_n),
        .rst_in_n   (rst_in_n),
        .state_o    (state),
        .clr_o      (clr),
        .cls_o      (cls),
        .cls_long_o (cls_long)
    );

    rstseq_classify u_cls (
        .clk        (clk),
        .por_n      (por_n),
        .clr_i      (clr),
        .cls_i      (cls),
        .cls_long_i (cls_long),
        .long_o     (long_flag),
        .short_o    (short_flag)
    );

    rstseq_outdec u_dec (
        .state_i   (state),
        .bidir_en  (bidir_en),
        .sys_rst_o (sys_rst),
        .drive_o   (pin_drive),
        .cfg_o     (cfg_open)
    );

endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk (
    input logic clk,
    input logic por_n,
    input logic rst_in_n,
    input logic bidir_en,
    input logic sys_rst,
    input logic pin_drive,
    input logic long_flag,
    input logic short_flag,
    input logic cfg_open
);

    // R7: classification flags are exclusive
    assert_flags_excl_R7: assert property (@(posedge clk) disable iff (!por_n)
        !(long_flag && short_flag));

    // R3: the pin is only driven inside a system reset
    assert_drive_in_rst_R3: assert property (@(posedge clk) disable iff (!por_n)
        pin_drive |-> sys_rst);

    // R6: configuration pins open only after a long classification
    assert_cfg_long_R6: assert property (@(posedge clk) disable iff (!por_n)
        cfg_open |-> long_flag);

    // R1: a reset only starts after the input was seen low
    assert_qual_low_R1: assert property (@(posedge clk) disable iff (!por_n)
        $rose(sys_rst) |-> !$past(rst_in_n));

    // R4: a short flag appears together with the end of the system reset
    assert_short_end_R4: assert property (@(posedge clk) disable iff (!por_n)
        $rose(short_flag) |-> $fell(sys_rst));

endmodule

bind rstseq_top rstseq_chk u_chk (
    .clk        (clk),
    .por_n      (por_n),
    .rst_in_n   (rst_in_n),
    .bidir_en   (bidir_en),
    .sys_rst    (sys_rst),
    .pin_drive  (pin_drive),
    .long_flag  (long_flag),
    .short_flag (short_flag),
    .cfg_open   (cfg_open)
);

// File: tb/rstseq_top_tb.sv
module rstseq_top_tb;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic ext_n = 1'b1;
    logic bidir_en = 1'b0;
    logic rst_in_n;
    logic pin;
    logic sys_rst, pin_drive, long_flag, short_flag, cfg_open;
    logic [15:0] dly = 16'hFFFF;
    int fd = 0;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        int rst;
        int drv;
        int cfg;
        bit lng;
    } exp_t;

    exp_t q[$];

    always #5 clk = ~clk;

    rstseq_top u_dut (
        .clk        (clk),
        .por_n      (por_n),
        .rst_in_n   (rst_in_n),
        .bidir_en   (bidir_en),
        .sys_rst    (sys_rst),
        .pin_drive  (pin_drive),
        .long_flag  (long_flag),
        .short_flag (short_flag),
        .cfg_open   (cfg_open)
    );

    // wired-AND pin followed by a filter of fd cycles
    always_comb pin = ext_n & ~pin_drive;
    always @(posedge clk) dly <= {dly[14:0], pin};
    always_comb rst_in_n = (fd == 0) ? pin : dly[fd-1];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor / scoreboard
    int rc = 0, dc = 0, cc = 0;
    bit seen = 1'b0;
    always @(negedge clk) begin
        if (por_n) begin
            if (sys_rst) begin rc++; seen = 1'b1; end
            if (pin_drive) dc++;
            if (cfg_open) cc++;
            if (seen && !sys_rst && !cfg_open) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R1 unexpected reset event", rc, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(rc == e.rst, "R2/R5/R8/R10 sys_rst length", rc, e.rst);
                    chk(dc == e.drv, "R3 pin_drive length", dc, e.drv);
                    chk(cc == e.cfg, "R6 cfg_open length", cc, e.cfg);
                    chk(long_flag == e.lng, "R4 long_flag", int'(long_flag), int'(e.lng));
                    chk(short_flag == !e.lng, "R4 short_flag", int'(short_flag), int'(!e.lng));
                end
                seen = 1'b0; rc = 0; dc = 0; cc = 0;
            end
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic low_run(input int n);
        ext_n = 1'b0;
        cycles(n);
        ext_n = 1'b1;
    endtask

    task automatic wait_done();
        while (q.size() != 0) @(negedge clk);
        cycles(30);
    endtask

    // unidirectional event, external low run of len cycles, no filter delay
    task automatic uni_event(input int len, input int glitch_at);
        exp_t e;
        @(negedge clk);
        bidir_en = 1'b0;
        fd = 0;
        if (len >= 1048) e = '{rst: len - 3, drv: 0, cfg: len - 1043, lng: 1'b1};
        else             e = '{rst: 1044, drv: 0, cfg: 0, lng: 1'b0};
        q.push_back(e);
        low_run(len);
        if (glitch_at > 0) begin
            cycles(glitch_at);
            low_run(6);
        end
        wait_done();
    endtask

    // bidirectional event with filter delay d
    task automatic bidir_event(input int d);
        exp_t e;
        @(negedge clk);
        bidir_en = 1'b1;
        fd = d;
        if (d >= 8) e = '{rst: 1037 + d, drv: 1024, cfg: d - 3, lng: 1'b1};
        else        e = '{rst: 1044, drv: 1024, cfg: 0, lng: 1'b0};
        q.push_back(e);
        low_run(6);
        wait_done();
        bidir_en = 1'b0;
        fd = 0;
    endtask

    initial begin
        cycles(3);
        chk(!sys_rst && !pin_drive && !cfg_open, "R9 outputs in power-on reset",
            int'({sys_rst, pin_drive, cfg_open}), 0);
        por_n = 1'b1;
        cycles(3);
        chk(!sys_rst && !pin_drive && !cfg_open && !long_flag && !short_flag,
            "R9 outputs after power-on release",
            int'({sys_rst, pin_drive, cfg_open, long_flag, short_flag}), 0);

        uni_event(4, 0);        // R1 minimum qualifying run, short
        uni_event(1100, 0);     // R5 long by holding the input

        // R1 rejected 3-cycle pulse: no reset, flags kept
        low_run(3);
        cycles(40);
        chk(!sys_rst, "R1 short pulse starts no reset", int'(sys_rst), 0);
        chk(long_flag && !short_flag, "R1 flags unchanged by rejected pulse",
            int'({long_flag, short_flag}), 2);

        uni_event(4, 200);      // R8 low glitch during the sequence ignored, R7 flags swap
        bidir_event(3);         // R3 drive, fast filter: short
        bidir_event(10);        // R3/R4 slow filter: long
        uni_event(1047, 0);     // R4 boundary: released just before the sample
        uni_event(1048, 0);     // R4 boundary: still low at the sample

        chk(q.size() == 0, "R10 all events completed", q.size(), 0);
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            chk(1'b0, "watchdog expired R10", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule